// File: doc/BRIEF.md
# Distributed Ring Return-Address Stack

The block predicts return addresses for a processor that runs several threads of one sequential program at once, each on its own processing element. Every element owns a private return-address stack. The stacks are linked in a ring that follows thread order, and links run both ways. A call pushes onto the stack of the element that fetched it. A return pops from that element's own stack. When that stack is empty, the pop walks back through older elements until it reaches the element that runs the oldest thread.

A single request port takes one operation per cycle: call, return, commit or squash. A commit retires the oldest thread. Its leftover entries move one per cycle, top entry first, under the bottom of the next element's stack, and the oldest-thread pointer then advances around the ring. A squash replays the element's action log in reverse. It pushes popped addresses back and takes pushed addresses off again. If the element's own stack is empty, that removal falls through to the successor's stack. A three-state machine controls the block. IDLE accepts requests. IDLE goes to MIGRATE on a commit, and MIGRATE returns to IDLE once the committing stack is empty. IDLE goes to UNDO on a squash, and UNDO returns to IDLE once that element's log is empty.

Top module: `ring_ret_stack`

## Requirements
- R1: After reset, busy is low, ret_valid is low, every stack is empty, element 0 holds the oldest thread, and a return on any element misses.
- R2: A return accepted in cycle t answers in cycle t+1 with ret_valid high. Addresses come back from an element's own stack in last-in, first-out order.
- R3: A return whose own stack is empty takes the top of the nearest older non-empty stack, searching down to the oldest element. If none is found, it answers ret_hit low with ret_addr zero. Misses are not logged.
- R4: A commit (req_op 2; req_pe ignored) raises busy in the next cycle. The oldest element's entries then move, top first, under the bottom of its successor's stack, the oldest-thread pointer advances by one around the ring, and the log of the committed element is cleared.
- R5: Requests that arrive while busy is high are ignored and produce no response.
- R6: A squash (req_op 3) replays the log in reverse. Undoing a return pushes the popped address back onto the squashed element's own stack.
- R7: Undoing a call pops the squashed element's own top. If that stack is empty, it pops the successor's top instead.
- R8: Each element logs at most LOG_DEPTH calls plus hitting returns per thread. Once the log is full, a call is dropped and a return answers with a miss without popping.
- R9: A call onto a full stack discards that stack's bottom entry.
- R10: When migration finds the successor full, the remaining, older migrating entries are discarded.
- R11: Operation codes are call 0 and return 1, carried on req_op. req_pe selects the element.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe |
| req_op | input | 2 | 0 call, 1 return, 2 commit, 3 squash |
| req_pe | input | $clog2(NUM_PE) | Target element for call, return and squash |
| req_addr | input | AW | Return address pushed by a call |
| busy | output | 1 | Migration or undo in progress; requests ignored |
| ret_valid | output | 1 | Return response strobe |
| ret_hit | output | 1 | Response carries a predicted address |
| ret_addr | output | AW | Predicted return address, zero on a miss |

## Verification
The cases that are hardest to reach are the two overflow drops, because the per-thread log cap keeps any single thread from filling a stack. The bench uses a shallow stack of six entries. It builds the contents up over several threads and commits, and it wraps the ring from the last element back to element 0. Returns issued from younger elements then borrow the surviving entries, which shows exactly which entries were discarded. A squash that reverses a call after a younger element has already borrowed that address is also staged. This forces the undo to fall through to the successor's stack.

// File: rtl/rrs_pkg.sv
package rrs_pkg;
    typedef enum logic [1:0] {
        OP_CALL   = 2'd0,
        OP_RET    = 2'd1,
        OP_COMMIT = 2'd2,
        OP_SQUASH = 2'd3
    } rrs_op_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_MIGRATE,
        ST_UNDO
    } rrs_state_e;
endpackage

// File: rtl/rrs_stack.sv
module rrs_stack #(
    parameter int DEPTH = 40,
    parameter int AW    = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push_top,
    input  logic          push_bot,
    input  logic          pop_top,
    input  logic [AW-1:0] din,
    output logic [AW-1:0] top,
    output logic          empty,
    output logic          full
);
    localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [AW-1:0] mem [DEPTH];
    logic [IW-1:0] base;
    logic [IW:0]   cnt;

    function automatic logic [IW-1:0] wrap(input logic [IW:0] i);
        return (int'(i) >= DEPTH) ? IW'(int'(i) - DEPTH) : IW'(i);
    endfunction

    assign empty = (cnt == '0);
    assign full  = (int'(cnt) == DEPTH);
    assign top   = mem[wrap({1'b0, base} + cnt - (IW+1)'(1))];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base <= '0;
            cnt  <= '0;
        end else if (push_top) begin
            if (full) begin
                mem[base] <= din;
                base      <= wrap({1'b0, base} + (IW+1)'(1));
            end else begin
                mem[wrap({1'b0, base} + cnt)] <= din;
                cnt <= cnt + (IW+1)'(1);
            end
        end else if (push_bot) begin
            if (!full) begin
                mem[(base == '0) ? IW'(DEPTH - 1) : base - IW'(1)] <= din;
                base <= (base == '0) ? IW'(DEPTH - 1) : base - IW'(1);
                cnt  <= cnt + (IW+1)'(1);
            end
        end else if (pop_top && !empty) begin
            cnt <= cnt - (IW+1)'(1);
        end
    end
endmodule

// File: rtl/rrs_log.sv
module rrs_log #(
    parameter int LOG_DEPTH = 4,
    parameter int AW        = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic          pop,
    input  logic          clr,
    input  logic          kind_in,
    input  logic [AW-1:0] addr_in,
    output logic          kind_top,
    output logic [AW-1:0] addr_top,
    output logic          empty,
    output logic          full
);
    localparam int CW = $clog2(LOG_DEPTH + 1);
    localparam int XW = (LOG_DEPTH > 1) ? $clog2(LOG_DEPTH) : 1;

    logic [AW-1:0] addr_q [LOG_DEPTH];
    logic          kind_q [LOG_DEPTH];
    logic [CW-1:0] cnt;

    assign empty    = (cnt == '0);
    assign full     = (int'(cnt) == LOG_DEPTH);
    assign kind_top = kind_q[XW'(cnt - CW'(1))];
    assign addr_top = addr_q[XW'(cnt - CW'(1))];

    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            cnt <= '0;
        end else if (push && !full) begin
            kind_q[XW'(cnt)] <= kind_in;
            addr_q[XW'(cnt)] <= addr_in;
            cnt <= cnt + CW'(1);
        end else if (pop && !empty) begin
            cnt <= cnt - CW'(1);
        end
    end
endmodule

// File: rtl/ring_ret_stack.sv
module ring_ret_stack
    import rrs_pkg::*;
#(
    parameter int NUM_PE    = 4,
    parameter int DEPTH     = 40,
    parameter int LOG_DEPTH = 4,
    parameter int AW        = 32,
    localparam int PW       = (NUM_PE > 1) ? $clog2(NUM_PE) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  logic [1:0]    req_op,
    input  logic [PW-1:0] req_pe,
    input  logic [AW-1:0] req_addr,
    output logic          busy,
    output logic          ret_valid,
    output logic          ret_hit,
    output logic [AW-1:0] ret_addr
);
    localparam logic KIND_CALL = 1'b0;
    localparam logic KIND_RET  = 1'b1;

    rrs_state_e    state, state_n;
    rrs_op_e       op;
    logic [PW-1:0] head, head_n, act_pe, act_n;

    logic [NUM_PE-1:0] st_push_top, st_push_bot, st_pop, st_empty, st_full;
    logic [AW-1:0]     st_din [NUM_PE];
    logic [AW-1:0]     st_top [NUM_PE];
    logic [NUM_PE-1:0] lg_push, lg_pop, lg_clr, lg_empty, lg_full, lg_kind;
    logic              lg_kind_in;
    logic [AW-1:0]     lg_addr_in;
    logic [AW-1:0]     lg_addr [NUM_PE];

    logic          rv_n, rh_n;
    logic [AW-1:0] ra_n;
    logic          src_found, src_stop;
    logic [PW-1:0] src_pe, cand;

    assign op = rrs_op_e'(req_op);

    function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
        return PW'((int'(p) + 1) % NUM_PE);
    endfunction

    for (genvar g = 0; g < NUM_PE; g++) begin : g_pe
        rrs_stack #(.DEPTH(DEPTH), .AW(AW)) u_stack (
            .clk(clk), .rst_n(rst_n),
            .push_top(st_push_top[g]), .push_bot(st_push_bot[g]), .pop_top(st_pop[g]),
            .din(st_din[g]), .top(st_top[g]), .empty(st_empty[g]), .full(st_full[g])
        );
        rrs_log #(.LOG_DEPTH(LOG_DEPTH), .AW(AW)) u_log (
            .clk(clk), .rst_n(rst_n),
            .push(lg_push[g]), .pop(lg_pop[g]), .clr(lg_clr[g]),
            .kind_in(lg_kind_in), .addr_in(lg_addr_in),
            .kind_top(lg_kind[g]), .addr_top(lg_addr[g]),
            .empty(lg_empty[g]), .full(lg_full[g])
        );
    end

    // Nearest non-empty stack at or before req_pe, never past the oldest element
    always_comb begin
        src_found = 1'b0;
        src_stop  = 1'b0;
        src_pe    = '0;
        for (int k = 0; k < NUM_PE; k++) begin
            cand = PW'((int'(req_pe) + NUM_PE - k) % NUM_PE);
            if (!src_found && !src_stop) begin
                if (!st_empty[cand]) begin
                    src_found = 1'b1;
                    src_pe    = cand;
                end else if (cand == head) begin
                    src_stop = 1'b1;
                end
            end
        end
    end

    // Next state and datapath controls
    always_comb begin
        state_n     = state;
        head_n      = head;
        act_n       = act_pe;
        st_push_top = '0;
        st_push_bot = '0;
        st_pop      = '0;
        lg_push     = '0;
        lg_pop      = '0;
        lg_clr      = '0;
        lg_kind_in  = KIND_CALL;
        lg_addr_in  = req_addr;
        rv_n        = 1'b0;
        rh_n        = 1'b0;
        ra_n        = '0;
        for (int i = 0; i < NUM_PE; i++) st_din[i] = '0;
        unique case (state)
            ST_IDLE: begin
                if (req_valid) begin
                    unique case (op)
                        OP_CALL: begin
                            if (!lg_full[req_pe]) begin
                                st_push_top[req_pe] = 1'b1;
                                st_din[req_pe]      = req_addr;
                                lg_push[req_pe]     = 1'b1;
                            end
                        end
                        OP_RET: begin
                            rv_n = 1'b1;
                            if (!lg_full[req_pe] && src_found) begin
                                rh_n            = 1'b1;
                                ra_n            = st_top[src_pe];
                                st_pop[src_pe]  = 1'b1;
                                lg_push[req_pe] = 1'b1;
                                lg_kind_in      = KIND_RET;
                                lg_addr_in      = st_top[src_pe];
                            end
                        end
                        OP_COMMIT: begin
                            state_n      = ST_MIGRATE;
                            act_n        = head;
                            lg_clr[head] = 1'b1;
                        end
                        OP_SQUASH: begin
                            state_n = ST_UNDO;
                            act_n   = req_pe;
                        end
                        default: ;
                    endcase
                end
            end
            ST_MIGRATE: begin
                if (st_empty[act_pe]) begin
                    state_n = ST_IDLE;
                    head_n  = nxt(act_pe);
                end else begin
                    st_pop[act_pe]           = 1'b1;
                    st_push_bot[nxt(act_pe)] = 1'b1;
                    st_din[nxt(act_pe)]      = st_top[act_pe];
                end
            end
            ST_UNDO: begin
                if (lg_empty[act_pe]) begin
                    state_n = ST_IDLE;
                end else begin
                    lg_pop[act_pe] = 1'b1;
                    if (lg_kind[act_pe] == KIND_RET) begin
                        st_push_top[act_pe] = 1'b1;
                        st_din[act_pe]      = lg_addr[act_pe];
                    end else if (!st_empty[act_pe]) begin
                        st_pop[act_pe] = 1'b1;
                    end else begin
                        st_pop[nxt(act_pe)] = 1'b1;
                    end
                end
            end
            default: state_n = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            head   <= '0;
            act_pe <= '0;
        end else begin
            state  <= state_n;
            head   <= head_n;
            act_pe <= act_n;
        end
    end

    // Registered outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ret_valid <= 1'b0;
            ret_hit   <= 1'b0;
            ret_addr  <= '0;
        end else begin
            ret_valid <= rv_n;
            ret_hit   <= rh_n;
            ret_addr  <= ra_n;
        end
    end

    assign busy = (state != ST_IDLE);
endmodule

// File: rtl/rrs_checker.sv
module rrs_checker #(
    parameter int AW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          req_valid,
    input logic [1:0]    req_op,
    input logic          busy,
    input logic          ret_valid,
    input logic          ret_hit,
    input logic [AW-1:0] ret_addr
);
    AST_RET_ANSWERED: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !busy && req_op == 2'd1) |=> ret_valid); // R2
    AST_RET_ONLY_WHEN_ASKED: assert property (@(posedge clk) disable iff (!rst_n)
        ret_valid |-> $past(req_valid && !busy && req_op == 2'd1)); // R5
    AST_MISS_ADDR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (ret_valid && !ret_hit) |-> (ret_addr == '0)); // R3
    AST_COMMIT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !busy && req_op == 2'd2) |=> busy); // R4
    AST_SQUASH_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !busy && req_op == 2'd3) |=> busy); // R6
    AST_NO_RESP_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        ret_valid |-> !busy); // R5
endmodule

bind ring_ret_stack rrs_checker #(.AW(AW)) u_chk (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
    .busy(busy), .ret_valid(ret_valid), .ret_hit(ret_hit), .ret_addr(ret_addr)
);

// File: tb/ring_ret_stack_tb.sv
module ring_ret_stack_tb;
    localparam int NPE = 4;
    localparam int AW  = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic [1:0]    req_op = 2'd0;
    logic [1:0]    req_pe = 2'd0;
    logic [AW-1:0] req_addr = '0;
    logic          busy, ret_valid, ret_hit;
    logic [AW-1:0] ret_addr;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic          q_hit  [$];
    logic [AW-1:0] q_addr [$];
    string         q_tag  [$];

    always #10 clk = ~clk;

    ring_ret_stack #(.NUM_PE(NPE), .DEPTH(6), .LOG_DEPTH(4), .AW(AW)) u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
        .req_pe(req_pe), .req_addr(req_addr), .busy(busy),
        .ret_valid(ret_valid), .ret_hit(ret_hit), .ret_addr(ret_addr)
    );

    task automatic check(input string tag, input logic [AW-1:0] act, input logic [AW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic issue(input logic [1:0] op, input int pe, input logic [AW-1:0] a);
        req_valid = 1'b1;
        req_op    = op;
        req_pe    = 2'(pe);
        req_addr  = a;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic call(input int pe, input logic [AW-1:0] a);
        issue(2'd0, pe, a);
    endtask

    task automatic ret(input int pe, input logic h, input logic [AW-1:0] a, input string tag);
        q_hit.push_back(h);
        q_addr.push_back(a);
        q_tag.push_back(tag);
        issue(2'd1, pe, '0);
    endtask

    task automatic wait_idle();
        while (busy) @(negedge clk);
    endtask

    task automatic commit();
        issue(2'd2, 0, '0);
        check("R4 busy after commit", 32'(busy), 32'd1);
        wait_idle();
    endtask

    task automatic squash(input int pe);
        issue(2'd3, pe, '0);
        wait_idle();
    endtask

    // Monitor: compare every response with the scoreboard head
    always @(negedge clk) begin
        if (rst_n && ret_valid) begin
            if (q_hit.size() == 0) begin
                checks++;
                errors++;
                $display("FAIL R5 unexpected response actual=%h expected=none", ret_addr);
            end else begin
                check({q_tag[0], " hit"}, 32'(ret_hit), 32'(q_hit[0]));
                check({q_tag[0], " addr"}, ret_addr, q_addr[0]);
                void'(q_hit.pop_front());
                void'(q_addr.pop_front());
                void'(q_tag.pop_front());
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 busy in reset", 32'(busy), 32'd0);
        check("R1 ret_valid in reset", 32'(ret_valid), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 busy after reset", 32'(busy), 32'd0);
        ret(2, 1'b0, '0, "R1 empty after reset");

        // Local LIFO and forwarding to the predecessor
        call(0, 32'h100);
        call(0, 32'h104);
        ret(0, 1'b1, 32'h104, "R2 local pop");
        ret(1, 1'b1, 32'h100, "R3 forwarded pop");

        // Undo of a pop, then undo of a call that falls through to the successor
        squash(1);
        ret(1, 1'b1, 32'h100, "R6 popped address restored");
        squash(1);
        squash(0);
        ret(1, 1'b0, '0, "R7 successor entry removed");
        ret(0, 1'b0, '0, "R7 own entries removed");

        // Commit migration, with a request dropped while busy
        call(0, 32'hA0);
        call(0, 32'hA1);
        call(1, 32'hB0);
        issue(2'd2, 0, '0);
        check("R4 busy after commit", 32'(busy), 32'd1);
        call(3, 32'hDEAD);
        wait_idle();
        ret(1, 1'b1, 32'hB0, "R4 successor top kept");
        ret(1, 1'b1, 32'hA1, "R4 migrated top");
        ret(1, 1'b1, 32'hA0, "R4 migrated bottom");
        ret(1, 1'b0, '0, "R3 oldest element empty");
        ret(3, 1'b0, '0, "R5 call while busy ignored");

        // Log cap
        call(2, 32'h20);
        call(2, 32'h21);
        call(2, 32'h22);
        call(2, 32'h23);
        call(2, 32'h24);
        ret(2, 1'b0, '0, "R8 return past cap misses");
        ret(3, 1'b1, 32'h23, "R8 call past cap dropped");

        // Migration overflow across the ring wrap
        commit();
        commit();
        call(0, 32'h50);
        call(0, 32'h51);
        call(0, 32'h52);
        call(0, 32'h53);
        commit();
        ret(1, 1'b1, 32'h53, "R10 successor entries");
        ret(1, 1'b1, 32'h52, "R10 successor entries");
        ret(1, 1'b1, 32'h51, "R10 successor entries");
        ret(1, 1'b1, 32'h50, "R10 successor entries");
        ret(2, 1'b1, 32'h22, "R10 kept migrated");
        ret(2, 1'b1, 32'h21, "R10 kept migrated");
        ret(2, 1'b0, '0, "R10 oldest migrated dropped");

        // Full stack push drops the bottom entry
        call(3, 32'h30);
        call(3, 32'h31);
        call(3, 32'h32);
        call(3, 32'h33);
        commit();
        commit();
        commit();
        commit();
        call(0, 32'h60);
        call(0, 32'h61);
        call(0, 32'h62);
        ret(1, 1'b1, 32'h62, "R9 top after overflow");
        ret(1, 1'b1, 32'h61, "R11 call code pushes");
        ret(1, 1'b1, 32'h60, "R9 order");
        ret(1, 1'b1, 32'h33, "R9 order");
        ret(2, 1'b1, 32'h32, "R9 order");
        ret(2, 1'b1, 32'h31, "R9 order");
        ret(2, 1'b0, '0, "R9 bottom entry dropped");

        repeat (3) @(negedge clk);
        check("R2 all responses seen", 32'(q_hit.size()), 32'd0);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule